// File: doc/BRIEF.md
# SPI Master Register and FIFO Front End

This block is the processor-facing half of an SPI master. Software reaches it over a 32-bit register bus that is addressed in words. It holds the configuration the serial engine needs: frame control, a second control word, the slave-select lines, the clock divider and the interrupt mask. It also holds one FIFO for each direction and reports their fill levels and a status word. Software writes words to the data register to queue them for transmission. The block hands those words to the serial engine over a valid/ready pair. Words that the engine receives arrive over a second valid/ready pair and wait in the receive FIFO until software reads the data register.

The enable register gates all traffic. While the block is disabled, configuration may be changed, the engine sees no transmit words and no receive words are accepted. Writing 0 to the enable register discards everything held in both FIFOs. The two threshold registers keep a written value only when it is below the FIFO depth. Software can therefore find the depth by writing rising values and noting the first one that does not read back.

Top module: `spi_reg_front`

## Requirements
- R1: After reset the enable register (word 2, byte 0x08) reads 0, the interrupt mask (word 11, byte 0x2C) reads 0xFF, both level registers read 0 and every control register reads 0.
- R2: While enabled, a write to the data register (word 24, byte 0x60) that finds the transmit FIFO not full stores the low DATA_W bits. Stored words leave on txData in write order, one per cycle in which txValid and txReady are both high. txValid is low whenever the block is disabled.
- R3: A data register write is ignored while the block is disabled or the transmit FIFO is full. The transmit level (word 8, byte 0x20) never exceeds DEPTH.
- R4: rxReady is high exactly when the block is enabled and the receive FIFO is not full. A word offered with rxValid in such a cycle is stored. A read of the data register returns the oldest stored word zero-extended and removes it. The receive level (word 9, byte 0x24) counts the stored words.
- R5: Reading the data register while the receive FIFO is empty returns 0 and leaves the receive level unchanged.
- R6: Writing a value with bit 0 clear to the enable register disables the block and empties both FIFOs in the same cycle.
- R7: Writes to control 0 (word 0), control 1 (word 1), slave select (word 4) and baud (word 5) take effect only while the block is disabled. They are ignored while it is enabled. The held values drive the cfg* outputs.
- R8: A write to either threshold register (transmit word 6, receive word 7) is kept only when the full 32-bit value is below DEPTH. Otherwise the previous value stays.
- R9: The status register (word 10, byte 0x28) packs the following bits: bit 1 is transmit not full, bit 2 is transmit empty, bit 3 is receive not empty and bit 4 is receive full. Bits 5 and 6, the error and collision flags, read 0, and so do bits 31 to 7.
- R10: Status bit 0, busy, is high when engineBusy is high, or when the block is enabled and the transmit FIFO holds at least one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 5 | Word address of the register access |
| busWrEn | input | 1 | Register write strobe |
| busWrData | input | 32 | Register write data |
| busRdEn | input | 1 | Register read strobe; pops the receive FIFO at the data address |
| busRdData | output | 32 | Read data for busAddr, valid in the same cycle |
| txValid | output | 1 | Transmit word offered to the serial engine |
| txReady | input | 1 | Serial engine takes the offered word |
| txData | output | DATA_W | Oldest transmit word |
| rxValid | input | 1 | Serial engine offers a received word |
| rxReady | output | 1 | Block accepts the offered word |
| rxData | input | DATA_W | Received word |
| engineBusy | input | 1 | Serial engine is in the middle of a frame |
| cfgEnable | output | 1 | Enable register value |
| cfgCtrl0 | output | 16 | Control 0 value |
| cfgCtrl1 | output | 16 | Control 1 value |
| cfgSlaveSel | output | SS_W | Slave-select register value |
| cfgBaud | output | 16 | Clock divider value |
| irqMask | output | 8 | Interrupt mask value |

## Verification
The transmit path is first filled to DEPTH with the engine stalled, so one extra word shows whether the full check works. It is then drained with txReady held high, and a scoreboard confirms the write order on txData. The receive path is offered DEPTH+1 words, so the stall at full can be seen apart from ordinary acceptance. Reading past the last stored word tells the zero-on-empty rule apart from a stale-data read. A threshold probe loop of the kind software uses must report exactly DEPTH. A mixed load of words in both FIFOs followed by a disable write shows that both FIFOs are emptied together, and that control writes are locked or open depending on the enable state.

// File: rtl/spi_front_pkg.sv
package spi_front_pkg;

  // Strobes passed from the register control to the FIFO datapath
  typedef struct packed {
    logic enable;
    logic flush;
    logic txPush;
    logic rxPop;
  } dpStrobe_t;

  // Word addresses of the register map
  localparam logic [4:0] A_CTRL0  = 5'd0;
  localparam logic [4:0] A_CTRL1  = 5'd1;
  localparam logic [4:0] A_ENABLE = 5'd2;
  localparam logic [4:0] A_SLVSEL = 5'd4;
  localparam logic [4:0] A_BAUD   = 5'd5;
  localparam logic [4:0] A_TXTHR  = 5'd6;
  localparam logic [4:0] A_RXTHR  = 5'd7;
  localparam logic [4:0] A_TXLVL  = 5'd8;
  localparam logic [4:0] A_RXLVL  = 5'd9;
  localparam logic [4:0] A_STATUS = 5'd10;
  localparam logic [4:0] A_IMASK  = 5'd11;
  localparam logic [4:0] A_DATA   = 5'd24;

endpackage

// File: rtl/spi_front_fifo.sv
module spi_front_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             flush,
  input  logic                             push,
  input  logic [W-1:0]                     pushData,
  input  logic                             pop,
  output logic [W-1:0]                     headData,
  output logic [$clog2(DEPTH+1)-1:0]       level,
  output logic                             full,
  output logic                             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             doPush, doPop;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      count <= count + CNT_W'(1);
      else if (doPop && !doPush) count <= count - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= pushData;
  end

  assign headData = mem[rdPtr];
  assign level    = count;
endmodule

// File: rtl/spi_front_dp.sv
module spi_front_dp
  import spi_front_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpStrobe_t                  strobe,
  input  logic [DATA_W-1:0]          pushData,
  output logic                       txValid,
  input  logic                       txReady,
  output logic [DATA_W-1:0]          txData,
  input  logic                       rxValid,
  output logic                       rxReady,
  input  logic [DATA_W-1:0]          rxData,
  output logic [DATA_W-1:0]          rxHead,
  output logic [$clog2(DEPTH+1)-1:0] txLevel,
  output logic [$clog2(DEPTH+1)-1:0] rxLevel,
  output logic                       txFull,
  output logic                       txEmpty,
  output logic                       rxFull,
  output logic                       rxEmpty
);
  logic txPop, rxPush;

  assign txValid = strobe.enable && !txEmpty;
  assign txPop   = txValid && txReady;
  assign rxReady = strobe.enable && !rxFull;
  assign rxPush  = rxValid && rxReady;

  spi_front_fifo #(.W(DATA_W), .DEPTH(DEPTH)) i_txFifo (
    .clk(clk), .rstN(rstN), .flush(strobe.flush),
    .push(strobe.txPush), .pushData(pushData),
    .pop(txPop), .headData(txData),
    .level(txLevel), .full(txFull), .empty(txEmpty)
  );

  spi_front_fifo #(.W(DATA_W), .DEPTH(DEPTH)) i_rxFifo (
    .clk(clk), .rstN(rstN), .flush(strobe.flush),
    .push(rxPush), .pushData(rxData),
    .pop(strobe.rxPop), .headData(rxHead),
    .level(rxLevel), .full(rxFull), .empty(rxEmpty)
  );
endmodule

// File: rtl/spi_front_ctrl.sv
module spi_front_ctrl
  import spi_front_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int SS_W   = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [4:0]                 busAddr,
  input  logic                       busWrEn,
  input  logic [31:0]                busWrData,
  input  logic                       busRdEn,
  output logic [31:0]                busRdData,
  input  logic                       engineBusy,
  input  logic [DATA_W-1:0]          rxHead,
  input  logic [$clog2(DEPTH+1)-1:0] txLevel,
  input  logic [$clog2(DEPTH+1)-1:0] rxLevel,
  input  logic                       txFull,
  input  logic                       txEmpty,
  input  logic                       rxFull,
  input  logic                       rxEmpty,
  output dpStrobe_t                  strobe,
  output logic [6:0]                 statusWord,
  output logic                       cfgEnable,
  output logic [15:0]                cfgCtrl0,
  output logic [15:0]                cfgCtrl1,
  output logic [SS_W-1:0]            cfgSlaveSel,
  output logic [15:0]                cfgBaud,
  output logic [7:0]                 irqMask
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic             enableReg;
  logic [LVL_W-1:0] txThr, rxThr;
  logic             cfgOpen, thrOk;

  function automatic logic hit(input logic [4:0] a);
    return busWrEn && (busAddr == a);
  endfunction

  assign cfgOpen = !enableReg;
  assign thrOk   = (busWrData < 32'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableReg   <= 1'b0;
      cfgCtrl0    <= '0;
      cfgCtrl1    <= '0;
      cfgSlaveSel <= '0;
      cfgBaud     <= '0;
      txThr       <= '0;
      rxThr       <= '0;
      irqMask     <= 8'hFF;
    end else begin
      if (hit(A_ENABLE)) enableReg <= busWrData[0];
      if (cfgOpen && hit(A_CTRL0))  cfgCtrl0    <= busWrData[15:0];
      if (cfgOpen && hit(A_CTRL1))  cfgCtrl1    <= busWrData[15:0];
      if (cfgOpen && hit(A_SLVSEL)) cfgSlaveSel <= busWrData[SS_W-1:0];
      if (cfgOpen && hit(A_BAUD))   cfgBaud     <= busWrData[15:0];
      if (thrOk && hit(A_TXTHR))    txThr       <= busWrData[LVL_W-1:0];
      if (thrOk && hit(A_RXTHR))    rxThr       <= busWrData[LVL_W-1:0];
      if (hit(A_IMASK))             irqMask     <= busWrData[7:0];
    end
  end

  always_comb begin
    strobe.enable = enableReg;
    strobe.flush  = hit(A_ENABLE) && !busWrData[0];
    strobe.txPush = hit(A_DATA) && enableReg && !txFull;
    strobe.rxPop  = busRdEn && (busAddr == A_DATA) && !rxEmpty;
  end

  assign statusWord = {1'b0, 1'b0, rxFull, !rxEmpty, txEmpty, !txFull,
                       engineBusy || (enableReg && !txEmpty)};
  assign cfgEnable  = enableReg;

  always_comb begin
    case (busAddr)
      A_CTRL0:  busRdData = 32'(cfgCtrl0);
      A_CTRL1:  busRdData = 32'(cfgCtrl1);
      A_ENABLE: busRdData = 32'(enableReg);
      A_SLVSEL: busRdData = 32'(cfgSlaveSel);
      A_BAUD:   busRdData = 32'(cfgBaud);
      A_TXTHR:  busRdData = 32'(txThr);
      A_RXTHR:  busRdData = 32'(rxThr);
      A_TXLVL:  busRdData = 32'(txLevel);
      A_RXLVL:  busRdData = 32'(rxLevel);
      A_STATUS: busRdData = 32'(statusWord);
      A_IMASK:  busRdData = 32'(irqMask);
      A_DATA:   busRdData = rxEmpty ? 32'd0 : 32'(rxHead);
      default:  busRdData = 32'd0;
    endcase
  end
endmodule

// File: rtl/spi_reg_front.sv
module spi_reg_front
  import spi_front_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int SS_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  input  logic              busRdEn,
  output logic [31:0]       busRdData,
  output logic              txValid,
  input  logic              txReady,
  output logic [DATA_W-1:0] txData,
  input  logic              rxValid,
  output logic              rxReady,
  input  logic [DATA_W-1:0] rxData,
  input  logic              engineBusy,
  output logic              cfgEnable,
  output logic [15:0]       cfgCtrl0,
  output logic [15:0]       cfgCtrl1,
  output logic [SS_W-1:0]   cfgSlaveSel,
  output logic [15:0]       cfgBaud,
  output logic [7:0]        irqMask
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  dpStrobe_t         strobe;
  logic [DATA_W-1:0] rxHead;
  logic [LVL_W-1:0]  txLevel, rxLevel;
  logic              txFull, txEmpty, rxFull, rxEmpty;
  logic [6:0]        statusWord;

  spi_front_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SS_W(SS_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdEn(busRdEn), .busRdData(busRdData),
    .engineBusy(engineBusy), .rxHead(rxHead),
    .txLevel(txLevel), .rxLevel(rxLevel),
    .txFull(txFull), .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .strobe(strobe), .statusWord(statusWord),
    .cfgEnable(cfgEnable), .cfgCtrl0(cfgCtrl0), .cfgCtrl1(cfgCtrl1),
    .cfgSlaveSel(cfgSlaveSel), .cfgBaud(cfgBaud), .irqMask(irqMask)
  );

  spi_front_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pushData(busWrData[DATA_W-1:0]),
    .txValid(txValid), .txReady(txReady), .txData(txData),
    .rxValid(rxValid), .rxReady(rxReady), .rxData(rxData),
    .rxHead(rxHead), .txLevel(txLevel), .rxLevel(rxLevel),
    .txFull(txFull), .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty)
  );
endmodule

// File: rtl/spi_reg_front_chk.sv
module spi_reg_front_chk #(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [4:0]       busAddr,
  input logic             busWrEn,
  input logic [31:0]      busWrData,
  input logic [31:0]      busRdData,
  input logic             txValid,
  input logic             rxReady,
  input logic             cfgEnable,
  input logic [15:0]      cfgCtrl0,
  input logic [15:0]      cfgBaud,
  input logic [LVL_W-1:0] txLevel,
  input logic [LVL_W-1:0] rxLevel,
  input logic [6:0]       statusWord
);
  AST_TX_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rstN)
    txLevel <= LVL_W'(DEPTH)); // R3

  AST_TX_IDLE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |-> !txValid); // R2

  AST_RX_FULL_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel == LVL_W'(DEPTH)) |-> !rxReady); // R4

  AST_FLUSH_ON_DISABLE: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 5'd2 && !busWrData[0]) |=> (txLevel == '0 && rxLevel == '0)); // R6

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    cfgEnable |=> ($stable(cfgCtrl0) && $stable(cfgBaud))); // R7

  AST_BUSY_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && txLevel != '0) |-> statusWord[0]); // R10

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 5'd24 && rxLevel == '0) |-> busRdData == 32'd0); // R5
endmodule

bind spi_reg_front spi_reg_front_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) i_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .busRdData(busRdData), .txValid(txValid),
  .rxReady(rxReady), .cfgEnable(cfgEnable), .cfgCtrl0(cfgCtrl0),
  .cfgBaud(cfgBaud), .txLevel(txLevel), .rxLevel(rxLevel),
  .statusWord(statusWord)
);

// File: tb/test_spi_reg_front.sv
module test_spi_reg_front;
  localparam int DW    = 16;
  localparam int DEPTH = 8;
  localparam int SSW   = 4;

  localparam logic [4:0] W_CTRL0 = 5'd0, W_ENABLE = 5'd2, W_SLVSEL = 5'd4, W_BAUD = 5'd5;
  localparam logic [4:0] W_TXTHR = 5'd6, W_RXTHR = 5'd7, W_TXLVL = 5'd8, W_RXLVL = 5'd9;
  localparam logic [4:0] W_STATUS = 5'd10, W_IMASK = 5'd11, W_DATA = 5'd24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] busAddr = '0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic txValid, rxReady, cfgEnable;
  logic txReady = 1'b0, rxValid = 1'b0, engineBusy = 1'b0;
  logic [DW-1:0] txData, rxData = '0;
  logic [15:0] cfgCtrl0, cfgCtrl1, cfgBaud;
  logic [SSW-1:0] cfgSlaveSel;
  logic [7:0] irqMask;

  int nVec = 0;
  int nMis = 0;
  bit done = 1'b0;
  logic [DW-1:0] txQ[$];
  logic [DW-1:0] rxQ[$];

  always #5 clk = ~clk;

  spi_reg_front #(.DATA_W(DW), .DEPTH(DEPTH), .SS_W(SSW)) i_spi_reg_front (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .txValid(txValid), .txReady(txReady), .txData(txData),
    .rxValid(rxValid), .rxReady(rxReady), .rxData(rxData),
    .engineBusy(engineBusy), .cfgEnable(cfgEnable), .cfgCtrl0(cfgCtrl0),
    .cfgCtrl1(cfgCtrl1), .cfgSlaveSel(cfgSlaveSel), .cfgBaud(cfgBaud),
    .irqMask(irqMask)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nMis++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  // Driver: queue an expected transmit word when the push should land
  task automatic pushTx(input logic [DW-1:0] d, input bit accept);
    wr(W_DATA, 32'(d));
    if (accept) txQ.push_back(d);
  endtask

  // Engine-side receive driver: expected word queued when rxReady is seen
  task automatic rxSend(input logic [DW-1:0] d);
    @(negedge clk);
    rxValid = 1'b1; rxData = d;
    #1 if (rxReady) rxQ.push_back(d);
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  // Monitor: every transmit handshake must match the scoreboard head (R2)
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (txValid && txReady) begin
        if (txQ.size() == 0) chk("R2 unexpected tx word", 32'(txData), 32'hxxxx_xxxx);
        else chk("R2 tx order", 32'(txData), 32'(txQ.pop_front()));
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      nMis++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nMis);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int found;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state, R9 status encoding at idle
    rd(W_ENABLE, v); chk("R1 enable", v, 32'd0);
    rd(W_IMASK, v);  chk("R1 mask", v, 32'hFF);
    rd(W_TXLVL, v);  chk("R1 tx level", v, 32'd0);
    rd(W_RXLVL, v);  chk("R1 rx level", v, 32'd0);
    rd(W_CTRL0, v);  chk("R1 ctrl0", v, 32'd0);
    rd(W_STATUS, v); chk("R9 idle status", v, 32'h06);

    // R3 data write ignored while disabled
    pushTx(16'h1111, 1'b0);
    rd(W_TXLVL, v); chk("R3 disabled push", v, 32'd0);

    // R7 configuration open while disabled
    wr(W_CTRL0, 32'h1234); wr(W_SLVSEL, 32'h1); wr(W_BAUD, 32'h10);
    rd(W_CTRL0, v); chk("R7 ctrl0 written", v, 32'h1234);
    chk("R7 cfgSlaveSel", 32'(cfgSlaveSel), 32'h1);
    chk("R7 cfgBaud", 32'(cfgBaud), 32'h10);

    wr(W_ENABLE, 32'h1);
    chk("R1 cfgEnable set", 32'(cfgEnable), 32'd1);
    wr(W_CTRL0, 32'hBEEF); wr(W_BAUD, 32'h22);
    rd(W_CTRL0, v); chk("R7 ctrl0 locked", v, 32'h1234);
    chk("R7 baud locked", 32'(cfgBaud), 32'h10);

    // R8 threshold range and depth probe
    for (int k = 1; k <= DEPTH; k++) begin
      wr(W_TXTHR, 32'(k));
      rd(W_TXTHR, v);
      chk("R8 tx threshold", v, (k < DEPTH) ? 32'(k) : 32'(DEPTH - 1));
    end
    wr(W_RXTHR, 32'h1_0000_002); rd(W_RXTHR, v); chk("R8 rx threshold wide", v, 32'd0);
    found = 0;
    for (int f = 1; f < 256; f++) begin
      wr(W_TXTHR, 32'(f));
      rd(W_TXTHR, v);
      if (v != 32'(f)) begin found = f; break; end
    end
    chk("R8 probed depth", 32'(found), 32'(DEPTH));
    wr(W_TXTHR, 32'd0);

    // R2/R3/R10 fill transmit FIFO with the engine stalled
    for (int i = 0; i < DEPTH; i++) pushTx(16'hA000 + 16'(i * 37), 1'b1);
    pushTx(16'hDEAD, 1'b0);
    rd(W_TXLVL, v);  chk("R3 full level", v, 32'(DEPTH));
    rd(W_STATUS, v); chk("R9 R10 tx full status", v, 32'h01);
    chk("R2 txValid while loaded", 32'(txValid), 32'd1);

    // drain
    @(negedge clk); txReady = 1'b1;
    for (int i = 0; i < 40; i++) begin
      rd(W_TXLVL, v);
      if (v == 0) break;
    end
    chk("R2 drained", v, 32'd0);
    chk("R2 scoreboard empty", 32'(txQ.size()), 32'd0);
    rd(W_STATUS, v); chk("R10 idle not busy", v, 32'h06);
    @(negedge clk); engineBusy = 1'b1;
    rd(W_STATUS, v); chk("R10 engine busy", v, 32'h07);
    @(negedge clk); engineBusy = 1'b0;

    // R4 receive path up to full, R5 empty read
    for (int i = 0; i <= DEPTH; i++) rxSend(16'h5000 + 16'(i * 11));
    chk("R4 accepted count", 32'(rxQ.size()), 32'(DEPTH));
    chk("R4 rxReady low at full", 32'(rxReady), 32'd0);
    rd(W_RXLVL, v);  chk("R4 rx level", v, 32'(DEPTH));
    rd(W_STATUS, v); chk("R9 rx full status", v, 32'h1E);
    for (int i = 0; i < DEPTH; i++) begin
      rd(W_DATA, v);
      chk("R4 rx order", v, 32'(rxQ.pop_front()));
    end
    rd(W_DATA, v);  chk("R5 empty read", v, 32'd0);
    rd(W_RXLVL, v); chk("R5 level after empty read", v, 32'd0);

    // R6 flush on disable
    @(negedge clk); txReady = 1'b0;
    for (int i = 0; i < 3; i++) pushTx(16'h7700 + 16'(i), 1'b1);
    rxSend(16'h0123); rxSend(16'h0456);
    rd(W_TXLVL, v); chk("R2 partial load", v, 32'd3);
    rd(W_RXLVL, v); chk("R4 partial load", v, 32'd2);
    wr(W_ENABLE, 32'h0);
    txQ.delete(); rxQ.delete();
    rd(W_TXLVL, v); chk("R6 tx flushed", v, 32'd0);
    rd(W_RXLVL, v); chk("R6 rx flushed", v, 32'd0);
    chk("R4 rxReady off when disabled", 32'(rxReady), 32'd0);
    pushTx(16'h9999, 1'b0);
    rd(W_TXLVL, v); chk("R3 push after disable", v, 32'd0);
    wr(W_CTRL0, 32'hBEEF);
    chk("R7 ctrl0 reopened", 32'(cfgCtrl0), 32'hBEEF);
    wr(W_ENABLE, 32'h1);
    @(negedge clk); txReady = 1'b1;
    #1 chk("R2 no stale word after flush", 32'(txValid), 32'd0);
    rd(W_DATA, v); chk("R5 no stale rx after flush", v, 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nMis);
    $finish;
  end
endmodule